// File: doc/BRIEF.md
# Display Flow Fixed-Priority Arbiter

This block picks one data request per cycle out of a small set of requesters and hands it to one of two identical display interface ports. A requester is a lane fed either by the multi-channel FIFO controller or by the display processor. Each lane presents a request flag, the interface it wants (one bit), a traffic class and a source identifier. The source identifier tells the downstream buffer where to fetch the data from.

Selection happens in two stages. First, each interface collects only the lanes aimed at it and keeps the most urgent one. The most urgent class is a synchronous (timed) flow, then a processor register access, then an asynchronous DMA flow. A second stage then compares the two interface candidates using the same class order. When the classes are equal, interface 0 is preferred.

The winner is registered. It stays granted for as long as its lane keeps its request high. Its target, class and source identifier are frozen at the moment of the grant and are steered to the chosen interface's buffer through a one-hot interface select.

Top module: `dfa_arbiter`

## Requirements
- R1: After reset, and until a request is seen, `gnt`, `gnt_valid`, `if_sel`, `gnt_if`, `gnt_cls` and `gnt_src` are all zero.
- R2: Class codes are 0 = synchronous, 1 = processor access, 2 = asynchronous DMA, and a lower code always wins whatever the target. Code 3 is reserved and its lane is never granted.
- R3: Among eligible lanes with the same class and the same target, the lane with the lowest index wins.
- R4: When the best candidates of the two interfaces have the same class, the one targeting interface 0 (`req_tgt` bit = 0) wins.
- R5: A request present before a clock edge, with no grant held, is granted at that edge. `gnt` is one-hot at bit i for lane i.
- R6: While a grant is held, `if_sel` has exactly one bit set: bit 0 for interface 0 and bit 1 for interface 1. `gnt_if` equals the winner's target bit, and `gnt_cls`/`gnt_src` equal the winner's class and source id as seen at the granting edge.
- R7: While the granted lane keeps its request high, the grant does not move, even if a higher-class request arrives.
- R8: Changes to the granted lane's target, class or source id while it is held leave `if_sel`, `gnt_if`, `gnt_cls` and `gnt_src` unchanged.
- R9: When the granted lane drops its request, the next edge grants the best of the remaining eligible requests, with no idle cycle, or goes idle if there are none.
- R10: At most one bit of `gnt` is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | NUM_REQ | Request flag per lane |
| req_tgt | input | NUM_REQ | Target interface per lane |
| req_cls | input | 2*NUM_REQ | Class code per lane, lane i at bits [2i+1:2i] |
| req_src | input | SRC_W*NUM_REQ | Source id per lane, lane i at bits [SRC_W*i +: SRC_W] |
| gnt | output | NUM_REQ | One-hot grant to the winning lane |
| gnt_valid | output | 1 | A grant is held |
| gnt_if | output | 1 | Interface of the held grant |
| if_sel | output | 2 | One-hot buffer steering: bit d selects interface d |
| gnt_cls | output | 2 | Class of the held grant |
| gnt_src | output | SRC_W | Source id routed with the held grant |

## Verification
Every combination of request flag, target and class over the four lanes is applied from the idle state. Each pattern comes with a rotating source id. The expected winner is computed as the smallest class, then target, then lane index. This sweep separates class ordering from target ordering and from index ordering, and it also exposes any reserved-class or source-steering mistake. Directed sequences then place a higher-class request against a held grant and alter the held lane's fields. They also drop the owner while a competitor is waiting, which distinguishes hold, freeze and back-to-back handover from a design that re-arbitrates every cycle.

// File: rtl/dfa_pkg.sv
package dfa_pkg;
    typedef enum logic [1:0] {
        CLS_SYNC  = 2'd0,
        CLS_CPU   = 2'd1,
        CLS_ASYNC = 2'd2,
        CLS_RSVD  = 2'd3
    } flow_cls_e;

    localparam int NUM_IF = 2;

    function automatic logic cls_eligible(input logic [1:0] cls);
        return cls != CLS_RSVD;
    endfunction
endpackage

// File: rtl/dfa_target_pick.sv
module dfa_target_pick
    import dfa_pkg::*;
#(
    parameter int NUM_REQ = 4,
    parameter int IDX_W   = 2,
    parameter bit TGT     = 1'b0
) (
    input  logic [NUM_REQ-1:0]   req_valid,
    input  logic [NUM_REQ-1:0]   req_tgt,
    input  logic [2*NUM_REQ-1:0] req_cls,
    output logic                 win_valid,
    output logic [IDX_W-1:0]     win_idx,
    output logic [1:0]           win_cls
);
    // stage one: best class aimed at this interface, lowest lane on ties
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_cls   = CLS_RSVD;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (req_valid[i] && (req_tgt[i] == TGT) && cls_eligible(req_cls[2*i +: 2])) begin
                if (!win_valid || (req_cls[2*i +: 2] < win_cls)) begin
                    win_valid = 1'b1;
                    win_idx   = IDX_W'(i);
                    win_cls   = req_cls[2*i +: 2];
                end
            end
        end
    end
endmodule

// File: rtl/dfa_if_pick.sv
module dfa_if_pick #(
    parameter int IDX_W = 2
) (
    input  logic [1:0]       cand_valid,
    input  logic [IDX_W-1:0] cand_idx0,
    input  logic [IDX_W-1:0] cand_idx1,
    input  logic [1:0]       cand_cls0,
    input  logic [1:0]       cand_cls1,
    output logic             win_valid,
    output logic             win_if,
    output logic [IDX_W-1:0] win_idx,
    output logic [1:0]       win_cls
);
    logic take_one;

    // stage two: interface 1 only if strictly more urgent or alone
    always_comb begin
        take_one  = cand_valid[1] && (!cand_valid[0] || (cand_cls1 < cand_cls0));
        win_valid = |cand_valid;
        win_if    = take_one;
        win_idx   = take_one ? cand_idx1 : cand_idx0;
        win_cls   = take_one ? cand_cls1 : cand_cls0;
    end
endmodule

// File: rtl/dfa_grant_hold.sv
module dfa_grant_hold #(
    parameter int NUM_REQ = 4,
    parameter int IDX_W   = 2,
    parameter int SRC_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_REQ-1:0]       req_valid,
    input  logic [SRC_W*NUM_REQ-1:0] req_src,
    input  logic                     win_valid,
    input  logic                     win_if,
    input  logic [IDX_W-1:0]         win_idx,
    input  logic [1:0]               win_cls,
    output logic [NUM_REQ-1:0]       gnt,
    output logic                     gnt_valid,
    output logic                     gnt_if,
    output logic [1:0]               if_sel,
    output logic [1:0]               gnt_cls,
    output logic [SRC_W-1:0]         gnt_src
);
    typedef struct packed {
        logic             active;
        logic [IDX_W-1:0] idx;
        logic             tif;
        logic [1:0]       cls;
        logic [SRC_W-1:0] src;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.active && req_valid[st_q.idx]) begin
            st_d = st_q;
        end else if (win_valid) begin
            st_d.active = 1'b1;
            st_d.idx    = win_idx;
            st_d.tif    = win_if;
            st_d.cls    = win_cls;
            st_d.src    = req_src[win_idx*SRC_W +: SRC_W];
        end else begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        gnt = '0;
        if (st_q.active) gnt[st_q.idx] = 1'b1;
        gnt_valid = st_q.active;
        gnt_if    = st_q.tif;
        if_sel    = st_q.active ? (st_q.tif ? 2'b10 : 2'b01) : 2'b00;
        gnt_cls   = st_q.cls;
        gnt_src   = st_q.src;
    end

    assert_one_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    assert_granted_requested_R5: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> |(gnt & $past(req_valid)));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        |(gnt & req_valid) |=> $stable(gnt));

    assert_frozen_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
        |(gnt & req_valid) |=> ($stable(if_sel) && $stable(gnt_cls) && $stable(gnt_src)));

    assert_route_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> ($countones(if_sel) == 1 && if_sel[gnt_if]));

    assert_no_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> (gnt_cls != 2'd3));
endmodule

// File: rtl/dfa_arbiter.sv
module dfa_arbiter
    import dfa_pkg::*;
#(
    parameter int NUM_REQ = 4,
    parameter int SRC_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_REQ-1:0]       req_valid,
    input  logic [NUM_REQ-1:0]       req_tgt,
    input  logic [2*NUM_REQ-1:0]     req_cls,
    input  logic [SRC_W*NUM_REQ-1:0] req_src,
    output logic [NUM_REQ-1:0]       gnt,
    output logic                     gnt_valid,
    output logic                     gnt_if,
    output logic [1:0]               if_sel,
    output logic [1:0]               gnt_cls,
    output logic [SRC_W-1:0]         gnt_src
);
    localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

    logic [NUM_IF-1:0] cand_valid;
    logic [IDX_W-1:0]  cand_idx [NUM_IF];
    logic [1:0]        cand_cls [NUM_IF];

    logic             win_valid;
    logic             win_if;
    logic [IDX_W-1:0] win_idx;
    logic [1:0]       win_cls;

    for (genvar d = 0; d < NUM_IF; d++) begin : g_tgt
        dfa_target_pick #(
            .NUM_REQ (NUM_REQ),
            .IDX_W   (IDX_W),
            .TGT     (1'(d))
        ) u_pick (
            .req_valid (req_valid),
            .req_tgt   (req_tgt),
            .req_cls   (req_cls),
            .win_valid (cand_valid[d]),
            .win_idx   (cand_idx[d]),
            .win_cls   (cand_cls[d])
        );
    end

    dfa_if_pick #(.IDX_W(IDX_W)) u_if_pick (
        .cand_valid (cand_valid),
        .cand_idx0  (cand_idx[0]),
        .cand_idx1  (cand_idx[1]),
        .cand_cls0  (cand_cls[0]),
        .cand_cls1  (cand_cls[1]),
        .win_valid  (win_valid),
        .win_if     (win_if),
        .win_idx    (win_idx),
        .win_cls    (win_cls)
    );

    dfa_grant_hold #(
        .NUM_REQ (NUM_REQ),
        .IDX_W   (IDX_W),
        .SRC_W   (SRC_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_src   (req_src),
        .win_valid (win_valid),
        .win_if    (win_if),
        .win_idx   (win_idx),
        .win_cls   (win_cls),
        .gnt       (gnt),
        .gnt_valid (gnt_valid),
        .gnt_if    (gnt_if),
        .if_sel    (if_sel),
        .gnt_cls   (gnt_cls),
        .gnt_src   (gnt_src)
    );

    // R4: equal-class candidates on both interfaces never route to interface 1
    assert_if0_on_tie_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_valid && (&cand_valid) && (cand_cls[0] == cand_cls[1])) |=> !gnt_if);
endmodule

// File: tb/tb_dfa_arbiter.sv
module tb_dfa_arbiter;
    localparam int NUM_REQ = 4;
    localparam int SRC_W   = 2;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [NUM_REQ-1:0]       req_valid = '0;
    logic [NUM_REQ-1:0]       req_tgt = '0;
    logic [2*NUM_REQ-1:0]     req_cls = '0;
    logic [SRC_W*NUM_REQ-1:0] req_src = '0;
    logic [NUM_REQ-1:0]       gnt;
    logic                     gnt_valid;
    logic                     gnt_if;
    logic [1:0]               if_sel;
    logic [1:0]               gnt_cls;
    logic [SRC_W-1:0]         gnt_src;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    dfa_arbiter #(.NUM_REQ(NUM_REQ), .SRC_W(SRC_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tgt(req_tgt),
        .req_cls(req_cls), .req_src(req_src), .gnt(gnt), .gnt_valid(gnt_valid),
        .gnt_if(gnt_if), .if_sel(if_sel), .gnt_cls(gnt_cls), .gnt_src(gnt_src)
    );

    function automatic logic [11:0] pack_out();
        return {gnt_valid, gnt, if_sel, gnt_if, gnt_cls, gnt_src};
    endfunction

    function automatic logic [11:0] pack_exp(input logic v, input int idx, input logic t,
                                             input logic [1:0] c, input logic [1:0] s);
        logic [3:0] g;
        g = v ? 4'(1 << idx) : 4'd0;
        return {v, g, (v ? (t ? 2'b10 : 2'b01) : 2'b00), (v ? t : 1'b0),
                (v ? c : 2'b00), (v ? s : 2'b00)};
    endfunction

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%03h expected=%03h", tag, act, exp);
        end
    endtask

    task automatic set_lane(input int i, input logic v, input logic t,
                            input logic [1:0] c, input logic [1:0] s);
        req_valid[i]      = v;
        req_tgt[i]        = t;
        req_cls[2*i +: 2] = c;
        req_src[2*i +: 2] = s;
    endtask

    initial begin
        wait (cycles >= 190000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=<190000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs zero under reset and after release with no requests
        check("R1", pack_out(), 12'h000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", pack_out(), 12'h000);

        // sweep: every flag/target/class combination from idle (R2 R3 R4 R5 R6 R10)
        for (int p = 0; p < 65536; p++) begin
            int best;
            for (int i = 0; i < NUM_REQ; i++) begin
                set_lane(i, p[4*i], p[4*i+1], 2'((p >> (4*i+2)) & 3), 2'(i + p));
            end
            best = 255;
            for (int i = 0; i < NUM_REQ; i++) begin
                int c;
                int key;
                c = (p >> (4*i+2)) & 3;
                key = c*8 + ((p >> (4*i+1)) & 1)*4 + i;
                if (p[4*i] && c != 3 && key < best) best = key;
            end
            @(negedge clk);
            if (best == 255)
                check("R2 reserved/none", pack_out(), 12'h000);
            else
                check("R2/R3/R4/R5/R6/R10 sweep", pack_out(),
                      pack_exp(1'b1, best % 4, 1'((best / 4) % 2), 2'(best / 8),
                               2'((best % 4) + p)));
            req_valid = '0;
            @(negedge clk);
            check("R9 idle after drop", pack_out(), 12'h000);
        end

        // R7: held async grant on interface 1 resists a sync newcomer
        set_lane(0, 1'b1, 1'b1, 2'd2, 2'd1);
        @(negedge clk);
        check("R5 directed", pack_out(), pack_exp(1'b1, 0, 1'b1, 2'd2, 2'd1));
        set_lane(1, 1'b1, 1'b0, 2'd0, 2'd2);
        repeat (3) @(negedge clk);
        check("R7 hold", pack_out(), pack_exp(1'b1, 0, 1'b1, 2'd2, 2'd1));

        // R8: owner alters its fields while held
        set_lane(0, 1'b1, 1'b0, 2'd0, 2'd3);
        repeat (2) @(negedge clk);
        check("R8 frozen", pack_out(), pack_exp(1'b1, 0, 1'b1, 2'd2, 2'd1));

        // R9: owner drops, waiting lane 1 granted at the very next edge
        req_valid[0] = 1'b0;
        @(negedge clk);
        check("R9 handover", pack_out(), pack_exp(1'b1, 1, 1'b0, 2'd0, 2'd2));
        req_valid = '0;
        @(negedge clk);
        check("R9 idle", pack_out(), 12'h000);

        // R3 directed: two equal-class lanes on same target, lowest index wins
        set_lane(2, 1'b1, 1'b1, 2'd1, 2'd0);
        set_lane(3, 1'b1, 1'b1, 2'd1, 2'd3);
        @(negedge clk);
        check("R3 directed", pack_out(), pack_exp(1'b1, 2, 1'b1, 2'd1, 2'd0));
        req_valid = '0;
        @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule